// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block holds the status register of a serial NOR flash device and carries out its write path. It watches an SPI mode-0 byte stream that is framed by an active-low chip select. From that stream it decodes the write-latch commands, the status write command and the status read command. It oversamples the serial clock, chip select and data input with the system clock. The serial clock must therefore run well below the system clock: each serial clock phase must last at least four system clocks.

A status write is committed only under three conditions: the write-enable latch is already set, chip select rises exactly after the command byte and the data byte, and hardware protection is not active. A committed write then runs as a self-timed busy cycle. While that cycle runs, the progress flag is visible through the status read command and every other command is dropped. The new protection fields take effect when the cycle ends, and the write-enable latch clears at the same moment. The four block-protect bits are also driven on a port for the address-protection logic that sits outside this block.

Top module: `spi_status_reg_ctrl`

## Requirements
- R1: Status byte layout is bit7 = write-disable flag, bit6 = 0, bits5..2 = block-protect field, bit1 = write-enable latch, bit0 = write-in-progress. Opcode 0x05 returns this byte MSB first, one bit per falling SCLK edge, for as many bytes as the frame lasts. Each byte is sampled afresh. MISO is 0 outside a read.
- R2: After reset, the write-enable latch and write-in-progress are 0. The write-disable flag and the block-protect field take the value of the NV_INIT parameter.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Each acts only when chip select rises after exactly one complete byte. Bytes are sampled MSB first on rising SCLK.
- R4: Opcode 0x01 followed by one data byte commits a status write only if the write-enable latch is 1 and chip select rises after exactly two complete bytes.
- R5: A committed write takes bit7 and bits5..2 from the data byte. Data bits 6, 1 and 0 have no effect.
- R6: A status write frame that ends off a byte boundary, or after too few or too many bytes, is rejected. It changes no bit, leaves the write-enable latch as it was, and starts no busy cycle.
- R7: When the write-disable flag is 1 and wpN is low, a status write is ignored and the write-enable latch is left unchanged. When wpN is high, the write-disable flag can be written, including back to 0.
- R8: A commit sets write-in-progress for BUSY_CYCLES system clocks. At the end of that time, write-in-progress and the write-enable latch return to 0 and the new protection bits appear.
- R9: While write-in-progress is 1, every command except 0x05 is ignored. A status read during the busy cycle shows write-in-progress = 1 and the old protection bits.
- R10: The blockProtect output always equals status bits5..2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiSclk | input | 1 | SPI serial clock, mode 0 |
| spiCsN | input | 1 | Active-low chip select framing a command |
| spiMosi | input | 1 | Serial data into the block |
| spiMiso | output | 1 | Serial status data out of the block |
| wpN | input | 1 | Active-low hardware write-protect pin |
| blockProtect | output | 4 | Current block-protect field |

## Verification
A wrong write-enable latch or protection state reaches the ports in two ways. It shows on the next status read frame, and the protection field also shows on blockProtect as soon as a busy cycle ends. A latch that stays set after a rejected frame, or clears after one, appears in bit1 of the read that follows. A busy cycle that starts when it should not shows as bit0 high in a read issued straight after the frame. A wrong commit decision under protection appears in the status read once the busy time has elapsed, because the protection bits stay old or change.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int BYTE_BITS = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_BITS);
  localparam int BP_W = 4;

  localparam logic [BYTE_BITS-1:0] OP_WREN = 8'h06;
  localparam logic [BYTE_BITS-1:0] OP_WRDI = 8'h04;
  localparam logic [BYTE_BITS-1:0] OP_RDSR = 8'h05;
  localparam logic [BYTE_BITS-1:0] OP_WRSR = 8'h01;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic commit;
  } sr_strobe_t;
endpackage

// File: rtl/sr_ctrl.sv
module sr_ctrl
  import sr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclk,
  input  logic                 csN,
  input  logic                 mosi,
  output logic                 miso,
  input  logic [BYTE_BITS-1:0] status,
  input  logic                 wel,
  input  logic                 wip,
  input  logic                 hwProtect,
  output sr_strobe_t           strobe,
  output logic                 wrSrwd,
  output logic [BP_W-1:0]      wrBp
);
  logic [2:0] sclkS;
  logic [1:0] csS;
  logic [1:0] mosiS;
  logic       csActPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkS     <= '0;
      csS       <= '1;
      mosiS     <= '0;
      csActPrev <= 1'b0;
    end else begin
      sclkS     <= {sclkS[1:0], sclk};
      csS       <= {csS[0], csN};
      mosiS     <= {mosiS[0], mosi};
      csActPrev <= ~csS[1];
    end
  end

  logic sclkRise, sclkFall, csActive, frameStart, frameEnd;
  assign sclkRise   = sclkS[1] & ~sclkS[2];
  assign sclkFall   = ~sclkS[1] & sclkS[2];
  assign csActive   = ~csS[1];
  assign frameStart = csActive & ~csActPrev;
  assign frameEnd   = ~csActive & csActPrev;

  logic [BYTE_BITS-2:0] shiftIn;
  logic [BYTE_BITS-1:0] newByte;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [1:0]           byteCnt;
  logic [BYTE_BITS-1:0] opcode;
  logic                 reading, loadPending, misoR;
  logic [BYTE_BITS-2:0] txReg;

  assign newByte = {shiftIn, mosiS[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn     <= '0;
      bitCnt      <= '0;
      byteCnt     <= '0;
      opcode      <= '0;
      wrSrwd      <= 1'b0;
      wrBp        <= '0;
      reading     <= 1'b0;
      loadPending <= 1'b0;
      txReg       <= '0;
      misoR       <= 1'b0;
    end else if (frameStart) begin
      bitCnt      <= '0;
      byteCnt     <= '0;
      reading     <= 1'b0;
      loadPending <= 1'b0;
      misoR       <= 1'b0;
    end else if (frameEnd) begin
      reading     <= 1'b0;
      loadPending <= 1'b0;
      misoR       <= 1'b0;
    end else if (csActive && sclkRise) begin
      shiftIn <= newByte[BYTE_BITS-2:0];
      bitCnt  <= bitCnt + 1'b1;
      if (bitCnt == BIT_CNT_W'(BYTE_BITS - 1)) begin
        if (byteCnt != 2'd3) byteCnt <= byteCnt + 2'd1;
        if (byteCnt == 2'd0) opcode <= newByte;
        if (byteCnt == 2'd1) begin
          wrSrwd <= newByte[7];
          wrBp   <= newByte[5:2];
        end
        if ((byteCnt == 2'd0 && newByte == OP_RDSR) || reading) begin
          reading     <= 1'b1;
          loadPending <= 1'b1;
        end
      end
    end else if (csActive && sclkFall && reading) begin
      if (loadPending) begin
        misoR       <= status[BYTE_BITS-1];
        txReg       <= status[BYTE_BITS-2:0];
        loadPending <= 1'b0;
      end else begin
        misoR <= txReg[BYTE_BITS-2];
        txReg <= {txReg[BYTE_BITS-3:0], 1'b0};
      end
    end
  end

  assign miso = misoR;

  logic aligned, cmdOk;
  assign aligned = (bitCnt == '0);
  assign cmdOk   = frameEnd & ~wip & aligned;

  always_comb begin
    strobe.setWel = cmdOk && byteCnt == 2'd1 && opcode == OP_WREN;
    strobe.clrWel = cmdOk && byteCnt == 2'd1 && opcode == OP_WRDI;
    strobe.commit = cmdOk && byteCnt == 2'd2 && opcode == OP_WRSR
                    && wel && !hwProtect;
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setWel, strobe.clrWel, strobe.commit})); // R3
  AST_BUSY_IGNORES_CMDS: assert property (@(posedge clk) disable iff (!rstN)
    wip |-> !strobe.setWel && !strobe.clrWel && !strobe.commit); // R9
  AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!csActive && !csActPrev) |-> !miso); // R1
endmodule

// File: rtl/sr_datapath.sv
module sr_datapath
  import sr_pkg::*;
#(
  parameter int BUSY_CYCLES = 64,
  parameter logic [7:0] NV_INIT = 8'h00
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wpN,
  input  sr_strobe_t           strobe,
  input  logic                 wrSrwd,
  input  logic [BP_W-1:0]      wrBp,
  output logic [BYTE_BITS-1:0] status,
  output logic                 wel,
  output logic                 wip,
  output logic                 hwProtect,
  output logic [BP_W-1:0]      blockProtect
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [1:0]      wpS;
  logic            srwd, pendSrwd;
  logic [BP_W-1:0] bp, pendBp;
  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wpS <= '1;
    else       wpS <= {wpS[0], wpN};
  end

  assign hwProtect = srwd & ~wpS[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srwd     <= NV_INIT[7];
      bp       <= NV_INIT[5:2];
      pendSrwd <= 1'b0;
      pendBp   <= '0;
      wel      <= 1'b0;
      wip      <= 1'b0;
      busyCnt  <= '0;
    end else begin
      if (strobe.setWel) wel <= 1'b1;
      if (strobe.clrWel) wel <= 1'b0;
      if (strobe.commit) begin
        wip      <= 1'b1;
        busyCnt  <= CNT_W'(BUSY_CYCLES - 1);
        pendSrwd <= wrSrwd;
        pendBp   <= wrBp;
      end else if (wip) begin
        if (busyCnt == '0) begin
          wip  <= 1'b0;
          wel  <= 1'b0;
          srwd <= pendSrwd;
          bp   <= pendBp;
        end else begin
          busyCnt <= busyCnt - 1'b1;
        end
      end
    end
  end

  assign status       = {srwd, 1'b0, bp, wel, wip};
  assign blockProtect = bp;

  AST_COMMIT_GUARDED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> wel && !hwProtect && !wip); // R4
  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(strobe.commit)); // R8
  AST_BUSY_END_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel); // R8
  AST_PROT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wip) |-> $stable(srwd) && $stable(bp)); // R7
endmodule

// File: rtl/spi_status_reg_ctrl.sv
module spi_status_reg_ctrl
  import sr_pkg::*;
#(
  parameter int BUSY_CYCLES = 64,
  parameter logic [7:0] NV_INIT = 8'h00
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            spiSclk,
  input  logic            spiCsN,
  input  logic            spiMosi,
  output logic            spiMiso,
  input  logic            wpN,
  output logic [BP_W-1:0] blockProtect
);
  sr_strobe_t           strobe;
  logic [BYTE_BITS-1:0] status;
  logic                 wel, wip, hwProtect, wrSrwd;
  logic [BP_W-1:0]      wrBp;

  sr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(spiSclk), .csN(spiCsN), .mosi(spiMosi),
    .miso(spiMiso), .status(status), .wel(wel), .wip(wip),
    .hwProtect(hwProtect), .strobe(strobe), .wrSrwd(wrSrwd), .wrBp(wrBp)
  );

  sr_datapath #(.BUSY_CYCLES(BUSY_CYCLES), .NV_INIT(NV_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .wpN(wpN), .strobe(strobe), .wrSrwd(wrSrwd),
    .wrBp(wrBp), .status(status), .wel(wel), .wip(wip),
    .hwProtect(hwProtect), .blockProtect(blockProtect)
  );
endmodule

// File: tb/test_spi_status_reg_ctrl.sv
module test_spi_status_reg_ctrl;
  localparam int BUSY = 600;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0, wpN = 1'b1;
  logic spiMiso;
  logic [3:0] blockProtect;

  int nChecks = 0, nFails = 0;

  always #4 clk = ~clk;

  spi_status_reg_ctrl #(.BUSY_CYCLES(BUSY), .NV_INIT(8'h00)) i_spi_status_reg_ctrl (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .wpN(wpN), .blockProtect(blockProtect)
  );

  // {wpN, data byte}
  localparam logic [8:0] VEC [8] = '{
    {1'b1, 8'hFF}, {1'b0, 8'h00}, {1'b1, 8'h43}, {1'b0, 8'h24},
    {1'b1, 8'h98}, {1'b0, 8'h04}, {1'b1, 8'h3C}, {1'b0, 8'hA0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic csDown();
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csUp();
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int nBits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nBits; i--) begin
      spiMosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spiMiso;
      spiSclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b0;
    end
  endtask

  task automatic readStatus(output logic [7:0] s);
    logic [7:0] d;
    csDown();
    xferBits(8'h05, 8, d);
    xferBits(8'h00, 8, s);
    csUp();
  endtask

  task automatic cmd1(input logic [7:0] op, input int extraBits);
    logic [7:0] d;
    csDown();
    xferBits(op, 8, d);
    if (extraBits > 0) xferBits(8'hFF, extraBits, d);
    csUp();
  endtask

  task automatic cmd2(input logic [7:0] op, input logic [7:0] data, input int dataBits);
    logic [7:0] d;
    csDown();
    xferBits(op, 8, d);
    xferBits(data, dataBits, d);
    csUp();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] s, s2, d, exp;
    logic mSrwd, mWel, hpm;
    logic [3:0] mBp;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R2 reset state
    check("R2 blockProtect", {4'h0, blockProtect}, 8'h00);
    readStatus(s);
    check("R2 status", s, 8'h00);

    // R3 WREN, and R1 repeated read within one frame
    cmd1(8'h06, 0);
    csDown(); xferBits(8'h05, 8, d); xferBits(8'h00, 8, s); xferBits(8'h00, 8, s2); csUp();
    check("R3 wren sets latch", s, 8'h02);
    check("R1 second status byte", s2, 8'h02);

    // R3 WRDI
    cmd1(8'h04, 0);
    readStatus(s);
    check("R3 wrdi clears latch", s, 8'h00);

    // R3 misaligned WREN ignored
    cmd1(8'h06, 3);
    readStatus(s);
    check("R3 misaligned wren", s, 8'h00);

    // R4 status write without latch
    cmd2(8'h01, 8'h3C, 8);
    repeat (BUSY + 100) @(negedge clk);
    readStatus(s);
    check("R4 write without latch", s, 8'h00);
    check("R4 blockProtect unchanged", {4'h0, blockProtect}, 8'h00);

    // R6 misaligned / short / long status writes
    cmd1(8'h06, 0);
    csDown(); xferBits(8'h01, 8, d); xferBits(8'h3C, 8, d); xferBits(8'hFF, 4, d); csUp();
    readStatus(s);
    check("R6 misaligned write, no busy", s, 8'h02);
    cmd2(8'h01, 8'h3C, 6);
    readStatus(s);
    check("R6 short write", s, 8'h02);
    csDown(); xferBits(8'h01, 8, d); xferBits(8'h3C, 8, d); xferBits(8'h00, 8, d); csUp();
    repeat (BUSY + 100) @(negedge clk);
    readStatus(s);
    check("R6 three-byte write", s, 8'h02);

    // vector table: R4 R5 R7 R10
    mSrwd = 1'b0; mBp = 4'h0; mWel = 1'b1;
    for (int v = 0; v < 8; v++) begin
      wpN = VEC[v][8];
      repeat (4) @(negedge clk);
      cmd1(8'h06, 0);
      mWel = 1'b1;
      cmd2(8'h01, VEC[v][7:0], 8);
      hpm = mSrwd && !VEC[v][8];
      if (!hpm) begin
        mSrwd = VEC[v][7];
        mBp   = VEC[v][5:2];
        mWel  = 1'b0;
      end
      repeat (BUSY + 100) @(negedge clk);
      readStatus(s);
      exp = {mSrwd, 1'b0, mBp, mWel, 1'b0};
      check(hpm ? "R7 protected write" : "R5 applied write", s, exp);
      check("R10 blockProtect", {4'h0, blockProtect}, {4'h0, mBp});
    end

    // R8 R9 busy cycle behaviour
    wpN = 1'b1;
    repeat (4) @(negedge clk);
    cmd1(8'h06, 0);
    cmd2(8'h01, 8'h14, 8);
    cmd1(8'h04, 0);
    readStatus(s);
    check("R9 read during busy", s, {mSrwd, 1'b0, mBp, 2'b11});
    repeat (BUSY + 100) @(negedge clk);
    readStatus(s);
    check("R8 after busy", s, 8'h14);
    check("R10 blockProtect after busy", {4'h0, blockProtect}, 8'h05);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule